// File: doc/BRIEF.md
# Six-Code Up/Down Ring Counter

This block is a three-bit synchronous counter that walks a fixed, non-binary ring of six codes. The forward order is 1, 2, 7, 6, 0, 5, after which it returns to 1. A single direction input chooses whether the next clock edge moves one place forward or one place backward around that ring. The codes 3 and 4 belong to no ring position. If the register ever holds one of them, the next edge moves it back into the ring.

The state register can be built in one of two ways, chosen by a parameter. The first feeds each flip-flop its next value directly, as a D-type storage element. The second derives a set/clear (J/K) excitation pair for each bit from the present state and the direction input. Both ways produce the same code on every edge. The outputs come straight from the register, so they are free of combinational glitches. A second parameter sets the code loaded by reset. It defaults to the ring's starting code. Other values exist only so that recovery from an unused code can be exercised.

Top module: `hexcnt_updown`

## Requirements
- R1: While `rst` is 1 at a rising edge of `clk`, the counter loads RESET_CODE (default 3'b001), whatever the value of `dir`.
- R2: With `rst`=0 and `dir`=0, each rising edge moves `q` forward along 1→2→7→6→0→5→1, with `q[2]` as the MSB.
- R3: With `rst`=0 and `dir`=1, each rising edge moves `q` backward along 1→5→0→6→7→2→1.
- R4: From code 3 or code 4, the next rising edge with `rst`=0 loads code 1 for either value of `dir`, and the counter never enters code 3 or 4 from a ring code.
- R5: `dir` is sampled on the same edge that updates `q`. Reversing `dir` in the middle of the ring changes the very next step, with no code skipped or repeated.
- R6: The D-style build (STYLE=STORE_D, value 0) and the J/K build (STYLE=STORE_JK, value 1) give identical `q` sequences for identical inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, loads RESET_CODE |
| dir | input | 1 | 0 steps forward around the ring, 1 steps backward |
| q | output | 3 | Registered present code, bit 2 most significant |

## Verification
A wrong internal state always appears on `q` itself, because the output is the state register. It can be caught one edge after it happens: a single bad excitation bit produces a code that is not the ring neighbour of the previous one. An unused code that does not recover would show up as a repeated or out-of-ring value on the following edge. The bench compares every edge against values taken from the ring orders. It does so for a D-style and a J/K-style instance side by side, and it uses two extra instances that start in codes 3 and 4 so that recovery is observed at the ports.

// File: rtl/hexcnt_pkg.sv
package hexcnt_pkg;

  localparam int unsigned CODE_W  = 3;
  localparam int unsigned RING_N  = 6;

  typedef logic [CODE_W-1:0] code_t;

  // forward order of the ring; backward order is the same list reversed
  localparam code_t RING [RING_N] = '{3'd1, 3'd2, 3'd7, 3'd6, 3'd0, 3'd5};
  localparam code_t HOME = 3'd1;

  typedef enum logic {
    STORE_D  = 1'b0,
    STORE_JK = 1'b1
  } store_e;

endpackage

// File: rtl/hexcnt_next.sv
module hexcnt_next
  import hexcnt_pkg::*;
(
  input  code_t cur,
  input  logic  dir,
  output code_t nxt
);

  // Codes outside the ring fall through to HOME, giving one-edge recovery.
  always_comb begin
    nxt = HOME;
    for (int i = 0; i < RING_N; i++) begin
      if (cur == RING[i]) begin
        nxt = dir ? RING[(i + RING_N - 1) % RING_N] : RING[(i + 1) % RING_N];
      end
    end
  end

endmodule

// File: rtl/hexcnt_cell.sv
module hexcnt_cell
  import hexcnt_pkg::*;
#(
  parameter store_e STYLE   = STORE_D,
  parameter logic   RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic tgt,
  output logic q
);

  generate
    if (STYLE == STORE_JK) begin : g_jk
      logic j, k;
      // minimal excitation: set only when rising, clear only when falling
      assign j = tgt & ~q;
      assign k = ~tgt & q;

      always_ff @(posedge clk) begin
        if (rst) begin
          q <= RST_VAL;
        end else begin
          case ({j, k})
            2'b10:   q <= 1'b1;
            2'b01:   q <= 1'b0;
            2'b11:   q <= ~q;
            default: q <= q;
          endcase
        end
      end

      assert_jk_set_R6: assert property (@(posedge clk) disable iff (rst)
        (j && !k) |=> q);
      assert_jk_clr_R6: assert property (@(posedge clk) disable iff (rst)
        (!j && k) |=> !q);
      assert_jk_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!j && !k) |=> $stable(q));
    end else begin : g_d
      always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= tgt;
      end
    end
  endgenerate

endmodule

// File: rtl/hexcnt_updown.sv
module hexcnt_updown
  import hexcnt_pkg::*;
#(
  parameter store_e STYLE      = STORE_D,
  parameter code_t  RESET_CODE = HOME
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir,
  output logic [CODE_W-1:0] q
);

  code_t nxt;

  hexcnt_next u_next (
    .cur (q),
    .dir (dir),
    .nxt (nxt)
  );

  generate
    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
      hexcnt_cell #(
        .STYLE   (STYLE),
        .RST_VAL (RESET_CODE[b])
      ) u_cell (
        .clk (clk),
        .rst (rst),
        .tgt (nxt[b]),
        .q   (q[b])
      );
    end
  endgenerate

  assert_reset_load_R1: assert property (@(posedge clk)
    rst |=> (q == RESET_CODE));

  assert_fwd_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (q == 3'd5 && !dir) |=> (q == 3'd1));
  assert_fwd_mid_R2: assert property (@(posedge clk) disable iff (rst)
    (q == 3'd7 && !dir) |=> (q == 3'd6));

  assert_back_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (q == 3'd1 && dir) |=> (q == 3'd5));
  assert_back_mid_R3: assert property (@(posedge clk) disable iff (rst)
    (q == 3'd0 && dir) |=> (q == 3'd6));

  assert_recover_R4: assert property (@(posedge clk) disable iff (rst)
    (q == 3'd3 || q == 3'd4) |=> (q == 3'd1));
  assert_stay_in_ring_R4: assert property (@(posedge clk) disable iff (rst)
    (q != 3'd3 && q != 3'd4) |=> (q != 3'd3 && q != 3'd4));

  assert_dir_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (q == 3'd2 && dir) |=> (q == 3'd1));

endmodule

// File: tb/hexcnt_updown_tb.sv
`timescale 1ns/1ps
module hexcnt_updown_tb;
  import hexcnt_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir = 1'b0;
  logic [2:0] q_d, q_jk, q_r3, q_r4;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hexcnt_updown #(.STYLE(STORE_D))  u_dut (.clk(clk), .rst(rst), .dir(dir), .q(q_d));
  hexcnt_updown #(.STYLE(STORE_JK)) u_jk  (.clk(clk), .rst(rst), .dir(dir), .q(q_jk));
  hexcnt_updown #(.STYLE(STORE_D),  .RESET_CODE(3'd3)) u_r3 (.clk(clk), .rst(rst), .dir(dir), .q(q_r3));
  hexcnt_updown #(.STYLE(STORE_JK), .RESET_CODE(3'd4)) u_r4 (.clk(clk), .rst(rst), .dir(dir), .q(q_r4));

  // entry: {req[2:0], rst, dir, expected q[2:0]}
  localparam int NV = 22;
  localparam logic [7:0] VEC [NV] = '{
    {3'd1, 1'b1, 1'b0, 3'd1},
    {3'd2, 1'b0, 1'b0, 3'd2}, {3'd2, 1'b0, 1'b0, 3'd7}, {3'd2, 1'b0, 1'b0, 3'd6},
    {3'd2, 1'b0, 1'b0, 3'd0}, {3'd2, 1'b0, 1'b0, 3'd5}, {3'd2, 1'b0, 1'b0, 3'd1},
    {3'd3, 1'b0, 1'b1, 3'd5}, {3'd3, 1'b0, 1'b1, 3'd0}, {3'd3, 1'b0, 1'b1, 3'd6},
    {3'd3, 1'b0, 1'b1, 3'd7}, {3'd3, 1'b0, 1'b1, 3'd2}, {3'd3, 1'b0, 1'b1, 3'd1},
    {3'd5, 1'b0, 1'b0, 3'd2}, {3'd5, 1'b0, 1'b0, 3'd7}, {3'd5, 1'b0, 1'b1, 3'd2},
    {3'd5, 1'b0, 1'b0, 3'd7}, {3'd5, 1'b0, 1'b0, 3'd6}, {3'd5, 1'b0, 1'b1, 3'd7},
    {3'd5, 1'b0, 1'b1, 3'd2},
    {3'd1, 1'b1, 1'b1, 3'd1},
    {3'd2, 1'b0, 1'b0, 3'd2}
  };

  function automatic string tag(input logic [2:0] r);
    case (r)
      3'd1:    return "R1";
      3'd2:    return "R2";
      3'd3:    return "R3";
      3'd4:    return "R4";
      3'd5:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns after the rising edge
  task automatic step(input logic r, input logic d);
    @(negedge clk);
    rst = r;
    dir = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3]);
      check(tag(VEC[i][7:5]), "D build", q_d, VEC[i][2:0]);
      // R6: J/K build must track the same codes
      check("R6", "JK build", q_jk, VEC[i][2:0]);
    end

    // R1: reset code parameter, then R4: one-edge recovery moving forward
    step(1'b1, 1'b0);
    check("R1", "reset code 3", q_r3, 3'd3);
    check("R1", "reset code 4", q_r4, 3'd4);
    step(1'b0, 1'b0);
    check("R4", "code 3 fwd", q_r3, 3'd1);
    check("R4", "code 4 fwd", q_r4, 3'd1);
    step(1'b0, 1'b0);
    check("R4", "after recovery fwd", q_r3, 3'd2);

    // R4: recovery while moving backward
    step(1'b1, 1'b1);
    check("R1", "reset code 3 dir1", q_r3, 3'd3);
    step(1'b0, 1'b1);
    check("R4", "code 3 back", q_r3, 3'd1);
    check("R4", "code 4 back", q_r4, 3'd1);
    step(1'b0, 1'b1);
    check("R4", "after recovery back", q_r4, 3'd5);

    // R1: reset held for several edges keeps the start code
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    check("R1", "held reset", q_d, 3'd1);
    check("R6", "held reset JK", q_jk, 3'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule